// File: doc/BRIEF.md
# Frequency Offset Qualification Controller

This block decides whether one reference clock may be used for locking. It combines two things: the reference's activity status, which comes from a separate monitor, and a measured signed frequency offset in steps of 0.1 ppm. The decision uses two windows and a dwell timer. A reference inside the inner (qualify) window must stay there for a programmed number of seconds before it is accepted. Once accepted, it is dropped only when it leaves the wider outer (disqualify) window or raises an activity alarm.

The dwell time is counted on a one-cycle-wide seconds tick. Software supplies the window magnitudes and the dwell setting as static inputs, and the inner window is expected to be narrower than the outer one. Both windows are symmetric: the block compares the absolute value of the offset against each limit.

Top module: `freq_qual_ctrl`

## Requirements
- R1: While reset is low, `state` reads 0 and `qualified` reads 0. After any reset the block starts from that idle state.
- R2: `state` encodes idle as 0, timing as 1 and qualified as 2, and never shows 3. `qualified` is 1 exactly when `state` is 2.
- R3: From idle, the block moves to timing on the next clock when `ref_active` is 1 and |`offset`| <= `qual_range`. Otherwise it stays idle, and ticks have no effect there.
- R4: In timing, the block moves to qualified on the clock of the (T+1)-th seconds tick counted since it entered timing, where T is `qual_time` (0 to 63). With T = 0, the first tick qualifies.
- R5: A low `ref_active` in timing or qualified returns the block to idle on the next clock.
- R6: In qualified, |`offset`| > `disq_range` returns the block to idle on the next clock.
- R7: In qualified, an active reference with `qual_range` < |`offset`| <= `disq_range` stays qualified.
- R8: In timing, |`offset`| > `qual_range` returns the block to idle on the next clock and discards the ticks counted so far.
- R9: `offset` is 11-bit two's complement. A negative value is judged by its magnitude, and -1024 has magnitude 1024, which lies outside any 10-bit range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| ref_active | input | 1 | 1 = reference active, 0 = activity alarm |
| offset | input | 11 | Signed frequency offset, 0.1 ppm per LSB |
| qual_range | input | 10 | Inner window magnitude, 0.1 ppm per LSB |
| disq_range | input | 10 | Outer window magnitude, 0.1 ppm per LSB |
| qual_time | input | 6 | Dwell time in seconds |
| qualified | output | 1 | Reference is qualified |
| state | output | 2 | Current state (0 idle, 1 timing, 2 qualified) |

## Verification
Every decision of this block is visible on `state` one clock after the inputs that cause it, so a wrong transition shows at the ports within one cycle. A wrong dwell count shows up as qualification arriving one tick early or one tick late. A timer that is not cleared on leaving timing shows up as a shortened dwell after re-entry. A wrong sign or magnitude treatment shows up at the symmetric window edges (+/-50, +/-100, +/-101) and at -1024.

// File: rtl/freq_qual_ctrl.sv
module freq_qual_ctrl #(
  parameter int OFS_W = 11,
  parameter int RNG_W = 10,
  parameter int TMR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick,
  input  logic             ref_active,
  input  logic [OFS_W-1:0] offset,
  input  logic [RNG_W-1:0] qual_range,
  input  logic [RNG_W-1:0] disq_range,
  input  logic [TMR_W-1:0] qual_time,
  output logic             qualified,
  output logic [1:0]       state
);

  localparam logic [1:0] S_IDLE = 2'd0;
  localparam logic [1:0] S_TIME = 2'd1;
  localparam logic [1:0] S_QUAL = 2'd2;
  localparam logic [TMR_W-1:0] TMR_MAX = '1;

  logic [1:0]       st_q;
  logic [TMR_W-1:0] tmr_q;
  logic [OFS_W-1:0] mag;
  logic             in_qual, out_disq;

  assign mag      = offset[OFS_W-1] ? (~offset + 1'b1) : offset;
  assign in_qual  = mag <= OFS_W'(qual_range);
  assign out_disq = mag >  OFS_W'(disq_range);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      tmr_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          tmr_q <= '0;
          if (ref_active && in_qual) st_q <= S_TIME;
        end
        S_TIME: begin
          if (!ref_active || !in_qual) begin
            st_q  <= S_IDLE;
            tmr_q <= '0;
          end else if (sec_tick) begin
            if (tmr_q >= qual_time) st_q <= S_QUAL;
            else if (tmr_q != TMR_MAX) tmr_q <= tmr_q + 1'b1;
          end
        end
        S_QUAL: begin
          tmr_q <= '0;
          if (!ref_active || out_disq) st_q <= S_IDLE;
        end
        default: begin
          st_q  <= S_IDLE;
          tmr_q <= '0;
        end
      endcase
    end
  end

  assign state     = st_q;
  assign qualified = (st_q == S_QUAL);

  AST_LEGAL_STATE: assert property (@(posedge clk) disable iff (!rst_n) st_q != 2'd3); // R2
  AST_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n) st_q == S_IDLE |=> st_q != S_QUAL); // R3
  AST_ENTER_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_QUAL && $past(st_q) != S_QUAL) |-> ($past(st_q) == S_TIME && $past(sec_tick))); // R4
  AST_ALARM_DROP: assert property (@(posedge clk) disable iff (!rst_n) !ref_active |=> st_q == S_IDLE); // R5
  AST_DISQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_QUAL && out_disq) |=> st_q == S_IDLE); // R6
  AST_HYST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_QUAL && ref_active && !out_disq) |=> st_q == S_QUAL); // R7
  AST_TIMING_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_TIME && !in_qual) |=> st_q == S_IDLE); // R8

endmodule

// File: tb/freq_qual_ctrl_test.sv
module freq_qual_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_tick = 1'b0;
  logic        ref_active = 1'b0;
  logic [10:0] offset = '0;
  logic [9:0]  qual_range = 10'd50;
  logic [9:0]  disq_range = 10'd100;
  logic [5:0]  qual_time = 6'd2;
  logic        qualified;
  logic [1:0]  state;

  int checks = 0;
  int fails = 0;

  freq_qual_ctrl uut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .ref_active(ref_active),
    .offset(offset), .qual_range(qual_range), .disq_range(disq_range),
    .qual_time(qual_time), .qualified(qualified), .state(state)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // vector: {active, tick, offset[10:0], expected state[1:0]}
  localparam int NV = 18;
  localparam logic [14:0] VEC [NV] = '{
    {1'b0, 1'b0, 11'sd0,    2'd0}, // R3 inactive: stay idle
    {1'b1, 1'b0, 11'sd60,   2'd0}, // R3 outside inner window
    {1'b1, 1'b0, -11'sd50,  2'd1}, // R3 R9 negative edge enters
    {1'b1, 1'b1, -11'sd50,  2'd1}, // R4 tick 1
    {1'b1, 1'b1, -11'sd50,  2'd1}, // R4 tick 2
    {1'b1, 1'b0, 11'sd51,   2'd0}, // R8 leave inner window
    {1'b1, 1'b0, 11'sd50,   2'd1}, // R3 re-enter
    {1'b1, 1'b1, 11'sd50,   2'd1}, // R8 timer restarted: tick 1
    {1'b1, 1'b1, 11'sd50,   2'd1}, // R4 tick 2
    {1'b1, 1'b1, 11'sd50,   2'd2}, // R4 tick 3 qualifies
    {1'b1, 1'b0, 11'sd100,  2'd2}, // R7 between windows
    {1'b1, 1'b0, -11'sd100, 2'd2}, // R7 R9 negative between windows
    {1'b1, 1'b0, 11'sd101,  2'd0}, // R6 beyond outer window
    {1'b1, 1'b0, 11'sd0,    2'd1}, // R3
    {1'b1, 1'b1, 11'sd0,    2'd1}, // R4
    {1'b1, 1'b1, 11'sd0,    2'd1}, // R4
    {1'b1, 1'b1, 11'sd0,    2'd2}, // R4
    {1'b0, 1'b0, 11'sd0,    2'd0}  // R5 alarm drops
  };

  task automatic check(input string req, input logic [1:0] exp);
    checks++;
    if (state !== exp || qualified !== (exp == 2'd2)) begin
      fails++;
      $display("FAIL %s: state=%0d qualified=%0b expected state=%0d qualified=%0b",
               req, state, qualified, exp, exp == 2'd2);
    end
  endtask

  task automatic step(input logic act, input logic tk, input logic [10:0] ofs);
    ref_active = act; sec_tick = tk; offset = ofs;
    @(posedge clk);
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 reset", 2'd0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][14], VEC[i][13], VEC[i][12:2]);
      check($sformatf("R2 vector %0d", i), VEC[i][1:0]);
    end

    // R4 zero dwell: first tick qualifies
    qual_time = 6'd0;
    step(1'b1, 1'b0, 11'sd5);  check("R4 enter", 2'd1);
    step(1'b1, 1'b1, 11'sd5);  check("R4 zero dwell", 2'd2);
    // R1 reset from qualified
    rst_n = 1'b0; step(1'b1, 1'b0, 11'sd5); check("R1 mid-run reset", 2'd0);
    rst_n = 1'b1;
    // R3 tick in idle has no effect
    step(1'b0, 1'b1, 11'sd5);  check("R3 tick idle", 2'd0);
    // R5 alarm during timing
    qual_time = 6'd3;
    step(1'b1, 1'b0, 11'sd5);  check("R5 enter", 2'd1);
    step(1'b0, 1'b1, 11'sd5);  check("R5 alarm in timing", 2'd0);
    // R9 -1024 never enters even with max range
    qual_range = 10'd1023; disq_range = 10'd1023;
    step(1'b1, 1'b0, 11'h400); check("R9 -1024", 2'd0);
    step(1'b1, 1'b0, 11'h401); check("R9 -1023", 2'd1);
    // R6 -1024 from qualified
    qual_time = 6'd0;
    step(1'b1, 1'b1, 11'h401); check("R6 qualify", 2'd2);
    step(1'b1, 1'b0, 11'h400); check("R6 R9 -1024 drops", 2'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule